// File: doc/BRIEF.md
# Nametable Mirroring Memory Controller

This block sits on the video address bus of a tile-based graphics engine and serves the 4 KiB screen-map window at 0x2000-0x2FFF. That window holds four logical 1 KiB screens laid out as a 2x2 grid: top left at 0x2000, top right at 0x2400, bottom left at 0x2800 and bottom right at 0x2C00. Only 2 KiB of internal video RAM backs them, so the block folds the four logical screens onto two physical 1 KiB pages. It does this by choosing the source of physical address bit 10 at run time.

A two-bit mode input selects the folding. In column (vertical) folding, screens in the same column alias each other. In row (horizontal) folding, screens in the same row alias each other. In single-page folding, all four screens map to one page, and an externally held page-select bit chooses that page. In four-screen mode the internal RAM is switched off and every access goes to an external RAM port that has full 4 KiB addressing.

Reads return data one cycle after the read strobe, together with a valid flag. A write takes effect on the clock edge that samples the write strobe.

Top module: `ntmap_ctrl`

## Requirements
- R1: `ram_ce` is high only when a read or write strobe is high, `vaddr[13:12]` equals 2'b10 and the mode is not four-screen.
- R2: While `ram_ce` is high, `ram_addr[9:0]` equals `vaddr[9:0]`.
- R3: In mode 2'd0 (column folding), `ram_addr[10]` equals `vaddr[10]`. As a result, 0x2000 and 0x2800 share storage, and so do 0x2400 and 0x2C00.
- R4: In mode 2'd1 (row folding), `ram_addr[10]` equals `vaddr[11]`. As a result, 0x2000 and 0x2400 share storage, and so do 0x2800 and 0x2C00.
- R5: In mode 2'd2 (single page), `ram_addr[10]` equals `page_sel` for all four screens.
- R6: In mode 2'd3 (four-screen), `ram_ce` stays low. A window access drives `ext_ce` high, with `ext_addr` equal to `vaddr[11:0]`, `ext_we` equal to `wr_en` and `ext_wdata` equal to `wdata`. Internal RAM contents are left unchanged.
- R7: A read in the window (`rd_en` high, `wr_en` low) raises `rdata_valid` on the next cycle. At that point `rdata` carries the addressed byte: the internal RAM byte in modes 0-2, or `ext_rdata` in mode 3.
- R8: A write is complete at the edge that samples it. A later read from any aliased address returns the most recent byte written to that physical location.
- R9: An access outside the window drives neither `ram_ce` nor `ext_ce`, does not raise `rdata_valid` and leaves stored data unchanged.
- R10: Whenever `rdata_valid` is low, including right after reset, `rdata` is zero.
- R11: When `rd_en` and `wr_en` are both high, the access is performed as a write, and `rdata_valid` stays low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vaddr | input | 14 | Video address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| mode | input | 2 | Folding mode: 0 column, 1 row, 2 single page, 3 four-screen |
| page_sel | input | 1 | Page chosen in single-page mode |
| ext_rdata | input | 8 | Read data from external RAM, valid the cycle after a read |
| rdata | output | 8 | Read data |
| rdata_valid | output | 1 | Read data valid |
| ram_addr | output | 11 | Internal RAM physical address |
| ram_ce | output | 1 | Internal RAM chip enable |
| ext_ce | output | 1 | External RAM chip enable |
| ext_we | output | 1 | External RAM write enable |
| ext_addr | output | 12 | External RAM address |
| ext_wdata | output | 8 | External RAM write data |

## Verification
The assertions assume that `mode` and `page_sel` are held steady for as long as they matter to an access, and that `ext_rdata` is produced by a synchronous RAM that answers one cycle after `ext_ce` is asserted with `ext_we` low. The bench changes mode only between full sweeps. It drives `page_sel` from an address bit, so the value is fixed within each single access. The external RAM is modelled as a one-cycle synchronous array. Strobes are driven only at falling edges, so every sampled input is stable at the rising edge.

// File: rtl/ntmap_pkg.sv
package ntmap_pkg;

  typedef enum logic [1:0] {
    NT_VERT   = 2'd0,
    NT_HORZ   = 2'd1,
    NT_SINGLE = 2'd2,
    NT_FOUR   = 2'd3
  } nt_mode_e;

  // Picks the source of physical page bit from the logical column bit,
  // the logical row bit or the held page select.
  function automatic logic fold_page(input nt_mode_e m, input logic col_bit,
                                     input logic row_bit, input logic sel);
    case (m)
      NT_VERT:   return col_bit;
      NT_HORZ:   return row_bit;
      NT_SINGLE: return sel;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ntmap_decode.sv
module ntmap_decode
  import ntmap_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int PAGE_W  = 10,
  parameter int TAG_W   = ADDR_W - PAGE_W - 2,
  parameter logic [TAG_W-1:0] WIN_TAG = 2'b10
) (
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [1:0]         mode,
  input  logic               page_sel,
  output logic               win_hit,
  output logic               int_sel,
  output logic               ext_sel,
  output logic [PAGE_W:0]    int_addr,
  output logic [PAGE_W+1:0]  ext_addr
);

  nt_mode_e mode_e;
  logic     access;
  logic     is_four;

  function automatic logic tag_match(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W] == WIN_TAG;
  endfunction

  always_comb begin
    mode_e   = nt_mode_e'(mode);
    access   = rd_en | wr_en;
    is_four  = (mode_e == NT_FOUR);
    win_hit  = tag_match(vaddr);
    int_sel  = access & win_hit & ~is_four;
    ext_sel  = access & win_hit & is_four;
    int_addr = {fold_page(mode_e, vaddr[PAGE_W], vaddr[PAGE_W+1], page_sel),
                vaddr[PAGE_W-1:0]};
    ext_addr = vaddr[PAGE_W+1:0];
  end

endmodule

// File: rtl/ntmap_ram.sv
module ntmap_ram #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end

endmodule

// File: rtl/ntmap_rdpath.sv
module ntmap_rdpath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_fire,
  input  logic          rd_from_ext,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] ext_rdata,
  output logic [DW-1:0] rdata,
  output logic          rdata_valid
);

  logic valid_q;
  logic src_ext_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      src_ext_q <= 1'b0;
    end else begin
      valid_q <= rd_fire;
      if (rd_fire) src_ext_q <= rd_from_ext;
    end
  end

  always_comb begin
    rdata_valid = valid_q;
    if (!valid_q)       rdata = '0;
    else if (src_ext_q) rdata = ext_rdata;
    else                rdata = ram_q;
  end

endmodule

// File: rtl/ntmap_ctrl.sv
module ntmap_ctrl #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 10,
  localparam int RAM_AW = PAGE_W + 1,
  localparam int EXT_AW = PAGE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        mode,
  input  logic              page_sel,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce,
  output logic              ext_ce,
  output logic              ext_we,
  output logic [EXT_AW-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata
);

  logic              win_hit;
  logic              int_sel;
  logic              ext_sel;
  logic              rd_fire;
  logic [DATA_W-1:0] ram_q;

  ntmap_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_decode (
    .vaddr    (vaddr),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .mode     (mode),
    .page_sel (page_sel),
    .win_hit  (win_hit),
    .int_sel  (int_sel),
    .ext_sel  (ext_sel),
    .int_addr (ram_addr),
    .ext_addr (ext_addr)
  );

  ntmap_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .ce    (int_sel),
    .we    (wr_en),
    .addr  (ram_addr),
    .wdata (wdata),
    .q     (ram_q)
  );

  always_comb begin
    ram_ce    = int_sel;
    ext_ce    = ext_sel;
    ext_we    = ext_sel & wr_en;
    ext_wdata = wdata;
    rd_fire   = rd_en & ~wr_en & (int_sel | ext_sel);
  end

  ntmap_rdpath #(.DW(DATA_W)) u_rdpath (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_fire     (rd_fire),
    .rd_from_ext (ext_sel),
    .ram_q       (ram_q),
    .ext_rdata   (ext_rdata),
    .rdata       (rdata),
    .rdata_valid (rdata_valid)
  );

endmodule

// File: rtl/ntmap_ctrl_chk.sv
module ntmap_ctrl_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] vaddr,
  input logic              rd_en,
  input logic              wr_en,
  input logic [1:0]        mode,
  input logic              page_sel,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_valid,
  input logic [PAGE_W:0]   ram_addr,
  input logic              ram_ce,
  input logic              ext_ce,
  input logic              win_hit
);

  a_r1_ce_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (win_hit && (rd_en || wr_en)));

  a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ce |-> (ram_addr[PAGE_W-1:0] == vaddr[PAGE_W-1:0]));

  a_r3_col_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce && mode == 2'd0) |-> (ram_addr[PAGE_W] == vaddr[PAGE_W]));

  a_r4_row_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce && mode == 2'd1) |-> (ram_addr[PAGE_W] == vaddr[PAGE_W+1]));

  a_r5_single_page: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_ce && mode == 2'd2) |-> (ram_addr[PAGE_W] == page_sel));

  a_r6_four_no_int: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !ram_ce);

  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_ce && ext_ce));

  a_r7_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && (ram_ce || ext_ce)) |=> rdata_valid);

  a_r9_no_valid_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_ce || ext_ce) |=> !rdata_valid);

  a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_valid |-> (rdata == '0));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rdata_valid);

endmodule

bind ntmap_ctrl ntmap_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vaddr       (vaddr),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .mode        (mode),
  .page_sel    (page_sel),
  .rdata       (rdata),
  .rdata_valid (rdata_valid),
  .ram_addr    (ram_addr),
  .ram_ce      (ram_ce),
  .ext_ce      (ext_ce),
  .win_hit     (win_hit)
);

// File: tb/ntmap_ctrl_test.sv
`timescale 1ns/1ps
module ntmap_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] vaddr = '0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [1:0]  mode = 2'd0;
  logic        page_sel = 1'b0;
  logic [7:0]  ext_rdata;
  logic [7:0]  rdata;
  logic        rdata_valid;
  logic [10:0] ram_addr;
  logic        ram_ce;
  logic        ext_ce;
  logic        ext_we;
  logic [11:0] ext_addr;
  logic [7:0]  ext_wdata;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  logic [7:0] iram [2048];
  logic [7:0] xram [4096];
  logic [7:0] xq = '0;

  always #10 clk = ~clk;

  ntmap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .mode(mode), .page_sel(page_sel), .ext_rdata(ext_rdata),
    .rdata(rdata), .rdata_valid(rdata_valid), .ram_addr(ram_addr),
    .ram_ce(ram_ce), .ext_ce(ext_ce), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata)
  );

  // external RAM: synchronous, one-cycle read
  always @(posedge clk) begin
    if (ext_ce) begin
      if (ext_we) xram[ext_addr] <= ext_wdata;
      else        xq <= xram[ext_addr];
    end
  end
  assign ext_rdata = xq;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected physical page from the folding rules
  function automatic int exp_page(input int m, input int off, input bit sel);
    if (m == 0) return (off / 1024) % 2;
    if (m == 1) return (off / 2048) % 2;
    return int'(sel);
  endfunction

  function automatic string fold_tag(input int m);
    if (m == 0) return "R3";
    if (m == 1) return "R4";
    return "R5";
  endfunction

  function automatic logic [7:0] pat(input int off, input int m);
    return 8'((off * 7 + m * 29 + off / 256) % 256);
  endfunction

  task automatic drive(input int addr, input bit rd, input bit wr,
                       input logic [7:0] d, input bit sel);
    @(negedge clk);
    vaddr = 14'(addr); rd_en = rd; wr_en = wr; wdata = d; page_sel = sel;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    #2;
  endtask

  task automatic fold_sweep(input int m);
    mode = 2'(m);
    for (int off = 0; off < 4096; off++) begin
      bit sel = bit'((off / 1024) % 2);
      int pa = exp_page(m, off, sel) * 1024 + off % 1024;
      drive(16'h2000 + off, 1'b0, 1'b1, pat(off, m), sel);
      chk(ram_ce == 1'b1 && ext_ce == 1'b0, "R1 window enable", int'(ram_ce), 1);
      chk(ram_addr[9:0] == 10'(off % 1024), "R2 low bits", int'(ram_addr[9:0]), off % 1024);
      chk(ram_addr == 11'(pa), fold_tag(m), int'(ram_addr), pa);
      iram[pa] = pat(off, m);
    end
    idle();
    for (int off = 0; off < 4096; off++) begin
      bit sel = bit'(((off / 2048) % 2) ^ 1);
      int pa = exp_page(m, off, sel) * 1024 + off % 1024;
      drive(16'h2000 + off, 1'b1, 1'b0, 8'h00, sel);
      idle();
      chk(rdata_valid == 1'b1, "R7 valid", int'(rdata_valid), 1);
      chk(rdata == iram[pa], "R8 aliased readback", int'(rdata), int'(iram[pa]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(rdata_valid == 1'b0, "R10 reset valid", int'(rdata_valid), 0);
    chk(rdata == 8'h00, "R10 reset data", int'(rdata), 0);
    chk(ram_ce == 1'b0, "R1 idle enable", int'(ram_ce), 0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    fold_sweep(0);
    fold_sweep(1);
    fold_sweep(2);

    // R9: outside the window, modes 0 and 3
    mode = 2'd0;
    for (int k = 0; k < 64; k++) begin
      int off = (k * 67) % 2048;
      drive(16'h0000 + off, 1'b0, 1'b1, 8'hA5, 1'b0);
      chk(ram_ce == 1'b0 && ext_ce == 1'b0, "R9 low enable", int'(ram_ce), 0);
      drive(16'h3000 + off, 1'b1, 1'b0, 8'h00, 1'b0);
      chk(ram_ce == 1'b0 && ext_ce == 1'b0, "R9 high enable", int'(ram_ce), 0);
      idle();
      chk(rdata_valid == 1'b0, "R9 no valid outside", int'(rdata_valid), 0);
      chk(rdata == 8'h00, "R10 zero while idle", int'(rdata), 0);
      drive(16'h2000 + off, 1'b1, 1'b0, 8'h00, 1'b0);
      idle();
      chk(rdata == iram[off], "R9 storage untouched", int'(rdata), int'(iram[off]));
    end

    // R11: read and write together act as a write
    drive(16'h2005, 1'b1, 1'b1, 8'h3C, 1'b0);
    idle();
    chk(rdata_valid == 1'b0, "R11 no valid on write", int'(rdata_valid), 0);
    iram[5] = 8'h3C;
    drive(16'h2805, 1'b1, 1'b0, 8'h00, 1'b0);
    idle();
    chk(rdata == 8'h3C, "R11 write took effect", int'(rdata), 8'h3C);

    // R6: four-screen goes external
    mode = 2'd3;
    drive(16'h1234, 1'b0, 1'b1, 8'h77, 1'b0);
    chk(ext_ce == 1'b0 && ram_ce == 1'b0, "R9 four-screen outside", int'(ext_ce), 0);
    for (int off = 0; off < 4096; off++) begin
      drive(16'h2000 + off, 1'b0, 1'b1, ~pat(off, 3), 1'b1);
      chk(ram_ce == 1'b0, "R6 internal off", int'(ram_ce), 0);
      chk(ext_ce == 1'b1 && ext_we == 1'b1, "R6 ext strobes", int'(ext_ce), 1);
      chk(ext_addr == 12'(off), "R6 ext address", int'(ext_addr), off);
      chk(ext_wdata == ~pat(off, 3), "R6 ext data", int'(ext_wdata), int'(~pat(off, 3)));
    end
    idle();
    for (int off = 0; off < 4096; off += 3) begin
      drive(16'h2000 + off, 1'b1, 1'b0, 8'h00, 1'b0);
      chk(ext_we == 1'b0, "R6 ext read strobe", int'(ext_we), 0);
      idle();
      chk(rdata_valid == 1'b1, "R7 ext valid", int'(rdata_valid), 1);
      chk(rdata == ~pat(off, 3), "R7 ext data", int'(rdata), int'(~pat(off, 3)));
    end

    // R6: internal contents survived the four-screen writes
    mode = 2'd0;
    for (int off = 0; off < 2048; off++) begin
      drive(16'h2000 + off, 1'b1, 1'b0, 8'h00, 1'b0);
      idle();
      chk(rdata == iram[off], "R6 internal preserved", int'(rdata), int'(iram[off]));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule